// File: doc/BRIEF.md
# Prime-Field Modular Adder

This block adds two residues modulo a prime and returns the reduced sum. It is meant for the datapath of an elliptic-curve unit working over a prime field. Both operands and the modulus are `WIDTH` bits wide. The caller must supply operands that are already reduced, so that each is strictly below the modulus.

The block is purely combinational, with no clock and no reset. It first forms the plain sum one bit wider than the operands, so the carry out is not lost. It then subtracts the modulus once, in a two's-complement value two bits wider than the operands. The top bit of that difference is its sign. When the sign is clear, the output is the difference. When the sign is set, the output is the uncorrected sum. Because both operands are below the modulus, one subtraction is always enough.

A parameter chooses how the two internal adders are built: an explicit ripple-carry chain or an inferred `+`. Both choices produce the same function.

Top module: `modadd_core`

## Requirements
- R1: For every legal input (a_i < mod_i and b_i < mod_i), sum_o equals (a_i + b_i) mod mod_i, and the selected internal value never has a bit set above the low WIDTH bits.
- R2: When a_i + b_i < mod_i, sum_o equals a_i + b_i, left uncorrected.
- R3: When a_i + b_i >= mod_i, sum_o equals a_i + b_i - mod_i.
- R4: When a_i + b_i equals mod_i exactly, sum_o is 0.
- R5: When a_i + b_i equals mod_i - 1, sum_o is mod_i - 1.
- R6: When a_i = b_i = mod_i - 1 with mod_i >= 2, sum_o is mod_i - 2.
- R7: The carry out of a_i + b_i is kept. For example, with WIDTH=8, mod_i=255 and a_i=b_i=254, sum_o is 253, even though the plain sum does not fit in 8 bits.
- R8: With WIDTH=4, the block meets R1 for every modulus from 1 to 15 and every legal operand pair.
- R9: The ripple-carry build (ARCH_RIPPLE) and the inferred build (ARCH_INFER) give identical sum_o for identical inputs.
- R10: sum_o follows a change on the inputs with no clock edge and no latency, within the same cycle as the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, below mod_i |
| b_i | input | WIDTH | Second operand, below mod_i |
| mod_i | input | WIDTH | Modulus, nonzero |
| sum_o | output | WIDTH | (a_i + b_i) mod mod_i |

## Verification
Every result is due in the same cycle as the stimulus, because no register lies between the inputs and sum_o. The bench changes the inputs on the falling clock edge and reads sum_o one nanosecond later, well before the next rising edge. Each comparison therefore tests the zero-latency behaviour and the arithmetic together. The 4-bit instance is swept exhaustively. The 8-bit instances receive seeded random pairs under several moduli, including the smallest moduli and one with no headroom above it, plus the directed equalities at p and p-1.

// File: rtl/modadd_pkg.sv
`timescale 1ns/1ps
package modadd_pkg;

  // Build variant for the internal adders
  typedef enum logic [0:0] {
    ARCH_RIPPLE = 1'b0,
    ARCH_INFER  = 1'b1
  } adder_arch_e;

endpackage

// File: rtl/modadd_adder.sv
`timescale 1ns/1ps
// Generic WIDTH-bit adder with carry in; no carry out is produced.
module modadd_adder #(
  parameter int unsigned             WIDTH = 9,
  parameter modadd_pkg::adder_arch_e ARCH  = modadd_pkg::ARCH_RIPPLE
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] s_o
);

  generate
    if (ARCH == modadd_pkg::ARCH_RIPPLE) begin : g_ripple
      logic [WIDTH-1:0] carry;
      assign carry[0] = cin_i;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign s_o[i] = x_i[i] ^ y_i[i] ^ carry[i];
        if (i < WIDTH - 1) begin : g_cy
          assign carry[i+1] = (x_i[i] & y_i[i]) | (carry[i] & (x_i[i] ^ y_i[i]));
        end
      end
    end else begin : g_infer
      always_comb begin
        s_o = x_i + y_i + {{(WIDTH-1){1'b0}}, cin_i};
      end
    end
  endgenerate

endmodule

// File: rtl/modadd_sel.sv
`timescale 1ns/1ps
// Picks the corrected or uncorrected value by the sign of the trial difference.
module modadd_sel #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned SUM_W  = WIDTH + 1,
  localparam int unsigned DIFF_W = WIDTH + 2
) (
  input  logic [SUM_W-1:0]  raw_i,
  input  logic [DIFF_W-1:0] diff_i,
  output logic [SUM_W-1:0]  pick_o
);

  logic neg;

  always_comb begin
    neg    = diff_i[DIFF_W-1];
    pick_o = neg ? raw_i : diff_i[SUM_W-1:0];
  end

endmodule

// File: rtl/modadd_core.sv
`timescale 1ns/1ps
// Top: (a + b) mod p with a single trial subtraction.
module modadd_core #(
  parameter int unsigned             WIDTH = 8,
  parameter modadd_pkg::adder_arch_e ARCH  = modadd_pkg::ARCH_RIPPLE
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] mod_i,
  output logic [WIDTH-1:0] sum_o
);

  localparam int unsigned SUM_W  = WIDTH + 1;
  localparam int unsigned DIFF_W = WIDTH + 2;

  logic [SUM_W-1:0]  raw_sum;
  logic [DIFF_W-1:0] trial_diff;
  logic [SUM_W-1:0]  sel_full;

  // Plain sum, widened so the carry lands in the top bit
  modadd_adder #(.WIDTH(SUM_W), .ARCH(ARCH)) u_sum (
    .x_i   ({1'b0, a_i}),
    .y_i   ({1'b0, b_i}),
    .cin_i (1'b0),
    .s_o   (raw_sum)
  );

  // raw_sum - mod_i as inverted addend plus one, two bits of headroom for a sign
  modadd_adder #(.WIDTH(DIFF_W), .ARCH(ARCH)) u_trial (
    .x_i   ({1'b0, raw_sum}),
    .y_i   (~{2'b00, mod_i}),
    .cin_i (1'b1),
    .s_o   (trial_diff)
  );

  modadd_sel #(.WIDTH(WIDTH)) u_sel (
    .raw_i  (raw_sum),
    .diff_i (trial_diff),
    .pick_o (sel_full)
  );

  assign sum_o = sel_full[WIDTH-1:0];

endmodule

// File: rtl/modadd_core_chk.sv
`timescale 1ns/1ps
// Property checker attached to every modadd_core instance.
module modadd_core_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] mod_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             sel_top_i
);

  logic [WIDTH:0] total;
  logic           legal;

  always_comb begin
    total = {1'b0, a_i} + {1'b0, b_i};
    legal = (a_i < mod_i) && (b_i < mod_i);
  end

  always_comb begin
    if (legal) begin
      // R1
      result_below_mod_chk: assert (sum_o < mod_i && !sel_top_i)
        else $error("sum_o out of range");
      // R2
      no_fold_chk: assert (!(total < {1'b0, mod_i}) || ({1'b0, sum_o} == total))
        else $error("small sum altered");
      // R3
      fold_chk: assert ((total < {1'b0, mod_i}) || ({1'b0, sum_o} == total - {1'b0, mod_i}))
        else $error("large sum not reduced");
      // R4
      exact_mod_chk: assert ((total != {1'b0, mod_i}) || (sum_o == '0))
        else $error("sum equal to modulus not zero");
    end
  end

endmodule

bind modadd_core modadd_core_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .mod_i     (mod_i),
  .sum_o     (sum_o),
  .sel_top_i (sel_full[WIDTH])
);

// File: tb/modadd_core_tb_top.sv
`timescale 1ns/1ps
module modadd_core_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] a8, b8, p8;
  logic [7:0] s8_rip, s8_inf;
  logic [3:0] a4, b4, p4;
  logic [3:0] s4;

  int unsigned vectors = 0;
  int unsigned fails   = 0;
  bit          done    = 1'b0;

  modadd_core #(.WIDTH(8), .ARCH(modadd_pkg::ARCH_RIPPLE)) dut_i (
    .a_i(a8), .b_i(b8), .mod_i(p8), .sum_o(s8_rip));
  modadd_core #(.WIDTH(8), .ARCH(modadd_pkg::ARCH_INFER)) dut_inf_i (
    .a_i(a8), .b_i(b8), .mod_i(p8), .sum_o(s8_inf));
  modadd_core #(.WIDTH(4), .ARCH(modadd_pkg::ARCH_RIPPLE)) dut_w4_i (
    .a_i(a4), .b_i(b4), .mod_i(p4), .sum_o(s4));

  function automatic int unsigned ref_mod(int unsigned a, int unsigned b, int unsigned p);
    return (a + b) % p;
  endfunction

  function automatic string tag_of(int unsigned a, int unsigned b, int unsigned p);
    if (a + b == p)     return "R4";
    if (a + b == p - 1) return "R5";
    if (a + b < p)      return "R2";
    return "R3";
  endfunction

  // R1 R10: drive on the falling edge, read back 1 ns later in the same cycle
  task automatic run8(input int unsigned a, input int unsigned b, input int unsigned p,
                      input string tag);
    int unsigned exp;
    @(negedge clk);
    a8 = a[7:0]; b8 = b[7:0]; p8 = p[7:0];
    #1;
    exp = ref_mod(a, b, p);
    vectors++;
    if (s8_rip != exp[7:0]) begin
      fails++;
      $display("FAIL %s/R1/R10 a=%0d b=%0d p=%0d actual=%0d expected=%0d",
               tag, a, b, p, s8_rip, exp);
    end
    vectors++;
    if (s8_inf != s8_rip) begin // R9
      fails++;
      $display("FAIL R9 a=%0d b=%0d p=%0d actual=%0d expected=%0d",
               a, b, p, s8_inf, s8_rip);
    end
  endtask

  // R8: 4-bit instance
  task automatic run4(input int unsigned a, input int unsigned b, input int unsigned p);
    int unsigned exp;
    @(negedge clk);
    a4 = a[3:0]; b4 = b[3:0]; p4 = p[3:0];
    #1;
    exp = ref_mod(a, b, p);
    vectors++;
    if (s4 != exp[3:0]) begin
      fails++;
      $display("FAIL R8/%s a=%0d b=%0d p=%0d actual=%0d expected=%0d",
               tag_of(a, b, p), a, b, p, s4, exp);
    end
  endtask

  initial begin
    int unsigned seed;
    int unsigned mods [6];
    seed = 32'd2718;
    void'($urandom(seed));
    a8 = '0; b8 = '0; p8 = 8'd1;
    a4 = '0; b4 = '0; p4 = 4'd1;

    // Initial state: smallest modulus
    run8(0, 0, 1, "R1");

    // Directed corners at WIDTH=8
    run8(100, 151, 251, "R4");
    run8(100, 150, 251, "R5");
    run8(250, 250, 251, "R6");
    run8(254, 254, 255, "R7");
    run8(254, 0, 255, "R2");
    run8(0, 0, 97, "R2");
    run8(96, 1, 97, "R4");
    run8(127, 127, 128, "R6");
    run8(1, 1, 2, "R4");
    run8(1, 0, 2, "R5");

    // R8: exhaustive sweep at WIDTH=4
    for (int p = 1; p < 16; p++)
      for (int a = 0; a < p; a++)
        for (int b = 0; b < p; b++)
          run4(a, b, p);
    run4(14, 14, 15); // R7 at 4 bits: carry out kept

    // Seeded random pairs at WIDTH=8 under several moduli
    mods = '{255, 251, 128, 97, 2, 1};
    foreach (mods[m]) begin
      for (int k = 0; k < 500; k++) begin
        int unsigned ra, rb;
        ra = $urandom % mods[m];
        rb = $urandom % mods[m];
        run8(ra, rb, mods[m], tag_of(ra, rb, mods[m]));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule